// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

The block holds one table of two-word buffer descriptors that a host bus reads and writes as plain words. A programmable split count divides the table. Indices below the count form the transmit ring and the indices from the count upward form the receive ring. Each descriptor has a status word, which carries the length, the control bits and the status bits, and a buffer address word.

The transmit engine waits on its current descriptor until the host marks it ready. It then hands the length, the address and the per-frame options to the transmit datapath over a request/done handshake. When the datapath finishes, the engine writes the completion status into the same descriptor in a single word write and moves on. The receive engine offers the buffer of the current descriptor while that descriptor is marked empty. When a frame completes, it stores the length and the error flags in the descriptor and advances.

Frames that arrive when no empty descriptor is offered are counted as dropped. A write-one-to-clear source register and a mask register produce one interrupt line. The datapath, the CRC and the movement of payload bytes lie outside the block.

Top module: `bd_ring_seq`

## Requirements
- R1: After reset the interrupt line, `tx_req` and `rx_ready` are low, the source and mask registers read 0, the split count reads 64, and every table word reads 0.
- R2: Byte address 0x400 + 8*i holds the status word of descriptor i and 0x400 + 8*i + 4 holds its buffer address. A host write to either word reads back unchanged.
- R3: The split count sits at byte address 0x20. A written value above 128 is stored as 128. Writing the count returns both ring positions to their first descriptor, and the receive ring starts at the index equal to the count.
- R4: When the current transmit descriptor has bit 15 (ready) set, `tx_req` rises and is held until `tx_done`. While it is high, `tx_len` = status[31:16], `tx_addr` = address word, `tx_pad` = bit 12 and `tx_crc` = bit 11, all stable.
- R5: While the current transmit descriptor's ready bit is clear, `tx_req` stays low, even if a later descriptor is ready.
- R6: On `tx_done` the status word is rewritten as {length, 0, bits 14:11 kept, 2'b00, `tx_status`[8:0]}, clearing ready in the same write.
- R7: `rx_ready` is high and `rx_addr` shows the buffer address while the current receive descriptor has bit 15 (empty) set. On `rx_done` its status word becomes {`rx_len`, 0, bits 14:13 kept, 4'b0000, `rx_flags`[8:0]}, and the descriptor is not offered again.
- R8: After a descriptor with bit 13 (wrap) set is processed, or after the last descriptor of its region, that ring returns to its first descriptor.
- R9: Completion raises a source bit only when the descriptor's bit 14 is set. Transmit raises bit 0, or bit 1 when any of status bits 8, 3, 2 or 0 is set. Receive raises bit 2, or bit 3 when any of flag bits 7:0 is set.
- R10: `rx_done` while `rx_ready` is low sets source bit 4 (frame dropped).
- R11: The source register at byte 0x04 clears the bits written as one, and a bit set in the same cycle stays set. `irq` is high exactly when a source bit with its mask bit (byte 0x08) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host word write strobe |
| host_addr | input | 11 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| tx_req | output | 1 | Transmit frame request |
| tx_len | output | 16 | Transmit frame length |
| tx_addr | output | 32 | Transmit buffer address |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Transmit completion pulse |
| tx_status | input | 9 | Transmit completion status |
| rx_ready | output | 1 | Empty receive buffer offered |
| rx_addr | output | 32 | Offered receive buffer address |
| rx_done | input | 1 | Receive frame completion pulse |
| rx_len | input | 16 | Received length including FCS |
| rx_flags | input | 9 | Receive flags |
| irq | output | 1 | Masked interrupt |

## Verification
The properties check on every cycle that the transmit request holds with stable length and address until done, and that it drops on completion. They also check that a claimed receive buffer is withdrawn at once, that a frame with no buffer offered sets the drop source, and that the split count never exceeds the table size. Only the bench scenarios can show that the written-back words hold the right length, control and status bits, that the rings stall and wrap at the right descriptor, and that the interrupt sources follow each descriptor's enable bit and the error classification.

// File: rtl/bd_ring_seq.sv
`timescale 1ns/1ps
module bd_ring_seq #(
  parameter int NDESC     = 128,
  parameter int TXN_RESET = 64
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [10:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        tx_req,
  output logic [15:0] tx_len,
  output logic [31:0] tx_addr,
  output logic        tx_pad,
  output logic        tx_crc,
  input  logic        tx_done,
  input  logic [8:0]  tx_status,
  output logic        rx_ready,
  output logic [31:0] rx_addr,
  input  logic        rx_done,
  input  logic [15:0] rx_len,
  input  logic [8:0]  rx_flags,
  output logic        irq
);
  localparam int IW = $clog2(NDESC);
  localparam int CW = IW + 1;
  localparam logic [CW-1:0] NMAX = CW'(NDESC);
  localparam logic [CW-1:0] LAST = CW'(NDESC - 1);

  typedef enum logic [1:0] {T_IDLE, T_BUSY, T_WB} tx_state_t;
  typedef enum logic {R_IDLE, R_WB} rx_state_t;

  logic [31:0] mem [2*NDESC];
  logic [CW-1:0] txn;
  logic [IW-1:0] tx_ptr, rx_off;
  logic [4:0] int_src, int_mask;
  tx_state_t ts;
  rx_state_t rs;
  logic [15:0] tx_len_q, rx_len_q;
  logic [3:0]  tx_ctl;
  logic [31:0] tx_abuf;
  logic [8:0]  tx_stat_q, rx_flags_q;
  logic [1:0]  rx_ctl;

  wire          tbl      = host_addr >= 11'h400;
  wire [IW:0]   hidx     = host_addr[IW+2:2];
  wire          host_tw  = host_wr && tbl;
  wire          reg_wr   = host_wr && !tbl;
  wire [CW-1:0] rx_idx_w = txn + CW'(rx_off);
  wire          rx_have  = rx_idx_w < NMAX;
  wire [IW-1:0] rx_idx   = rx_idx_w[IW-1:0];
  wire [IW:0]   tx_si    = {tx_ptr, 1'b0};
  wire [IW:0]   rx_si    = {rx_idx, 1'b0};

  assign tx_req   = ts == T_BUSY;
  assign tx_len   = tx_len_q;
  assign tx_addr  = tx_abuf;
  assign tx_pad   = tx_ctl[1];
  assign tx_crc   = tx_ctl[0];
  assign rx_ready = rs == R_IDLE && rx_have && mem[rx_si][15];
  assign rx_addr  = mem[{rx_idx, 1'b1}];

  wire tx_we  = ts == T_WB && !host_tw;
  wire rx_we  = rs == R_WB && !host_tw && !tx_we;
  wire tx_err = tx_stat_q[8] | tx_stat_q[3] | tx_stat_q[2] | tx_stat_q[0];
  wire rx_err = |rx_flags_q[7:0];
  wire [31:0] tx_wb = {tx_len_q, 1'b0, tx_ctl, 2'b00, tx_stat_q};
  wire [31:0] rx_wb = {rx_len_q, 1'b0, rx_ctl, 4'b0000, rx_flags_q};

  wire [4:0] int_set = {rx_done && !rx_ready,
                        rx_we && rx_ctl[1] && rx_err,
                        rx_we && rx_ctl[1] && !rx_err,
                        tx_we && tx_ctl[3] && tx_err,
                        tx_we && tx_ctl[3] && !tx_err};
  wire [4:0] int_clr = (reg_wr && host_addr == 11'h004) ? host_wdata[4:0] : 5'd0;
  assign irq = |(int_src & int_mask);

  wire [IW-1:0] tx_next = (tx_ctl[2] || CW'(tx_ptr) == txn - 1'b1) ? '0 : tx_ptr + 1'b1;
  wire [IW-1:0] rx_next = (rx_ctl[0] || rx_idx_w == LAST) ? '0 : rx_off + 1'b1;
  wire [CW-1:0] txn_wr  = (host_wdata > 32'(NDESC)) ? NMAX : host_wdata[CW-1:0];

  always_comb begin
    if (tbl) host_rdata = mem[hidx];
    else begin
      case (host_addr)
        11'h004: host_rdata = {27'd0, int_src};
        11'h008: host_rdata = {27'd0, int_mask};
        11'h020: host_rdata = {{(32-CW){1'b0}}, txn};
        default: host_rdata = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*NDESC; i++) mem[i] <= '0;
    end else if (host_tw) mem[hidx] <= host_wdata;
    else if (tx_we) mem[tx_si] <= tx_wb;
    else if (rx_we) mem[rx_si] <= rx_wb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn <= CW'(TXN_RESET);
      tx_ptr <= '0;
      rx_off <= '0;
      int_src <= '0;
      int_mask <= '0;
      ts <= T_IDLE;
      rs <= R_IDLE;
      tx_len_q <= '0;
      tx_ctl <= '0;
      tx_abuf <= '0;
      tx_stat_q <= '0;
      rx_len_q <= '0;
      rx_flags_q <= '0;
      rx_ctl <= '0;
    end else begin
      int_src <= (int_src & ~int_clr) | int_set;
      if (reg_wr && host_addr == 11'h008) int_mask <= host_wdata[4:0];

      case (ts)
        T_IDLE: if (txn != '0 && mem[tx_si][15]) begin
          tx_len_q <= mem[tx_si][31:16];
          tx_ctl   <= mem[tx_si][14:11];
          tx_abuf  <= mem[{tx_ptr, 1'b1}];
          ts       <= T_BUSY;
        end
        T_BUSY: if (tx_done) begin
          tx_stat_q <= tx_status;
          ts        <= T_WB;
        end
        T_WB: if (tx_we) begin
          tx_ptr <= tx_next;
          ts     <= T_IDLE;
        end
        default: ts <= T_IDLE;
      endcase

      case (rs)
        R_IDLE: if (rx_done && rx_ready) begin
          rx_ctl     <= mem[rx_si][14:13];
          rx_len_q   <= rx_len;
          rx_flags_q <= rx_flags;
          rs         <= R_WB;
        end
        default: if (rx_we) begin
          rx_off <= rx_next;
          rs     <= R_IDLE;
        end
      endcase

      if (reg_wr && host_addr == 11'h020) begin
        txn    <= txn_wr;
        tx_ptr <= '0;
        rx_off <= '0;
      end
    end
  end
endmodule

module bd_ring_seq_chk #(
  parameter int NDESC = 128
)(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tx_req,
  input logic                   tx_done,
  input logic [15:0]            tx_len,
  input logic [31:0]            tx_addr,
  input logic                   rx_done,
  input logic                   rx_ready,
  input logic [4:0]             int_src,
  input logic [$clog2(NDESC):0] txn
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done |=> tx_req && $stable(tx_len) && $stable(tx_addr)); // R4
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_done |=> !tx_req); // R6
  AST_RX_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_ready |=> !rx_ready); // R7
  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_ready |=> int_src[4]); // R10
  AST_SPLIT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    txn <= ($clog2(NDESC)+1)'(NDESC)); // R3
endmodule

bind bd_ring_seq bd_ring_seq_chk #(.NDESC(NDESC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_done(tx_done),
  .tx_len(tx_len), .tx_addr(tx_addr), .rx_done(rx_done), .rx_ready(rx_ready),
  .int_src(int_src), .txn(txn));

// File: tb/bd_ring_seq_test.sv
`timescale 1ns/1ps
module bd_ring_seq_test;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0;
  logic [10:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic tx_req, tx_pad, tx_crc, rx_ready, irq;
  logic [15:0] tx_len;
  logic [31:0] tx_addr, rx_addr;
  logic tx_done = 0, rx_done = 0;
  logic [8:0] tx_status = 0, rx_flags = 0;
  logic [15:0] rx_len = 0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  bd_ring_seq uut (.*);

  function automatic logic [10:0] sa(input int i); return 11'(32'h400 + i*8); endfunction
  function automatic logic [10:0] aa(input int i); return 11'(32'h404 + i*8); endfunction
  function automatic logic [31:0] txwb(input logic [15:0] l, input logic [3:0] c, input logic [8:0] s);
    return {l, 1'b0, c, 2'b00, s};
  endfunction
  function automatic logic [31:0] rxwb(input logic [15:0] l, input logic [1:0] c, input logic [8:0] f);
    return {l, 1'b0, c, 4'b0000, f};
  endfunction
  function automatic logic [4:0] txsrc(input logic ie, input logic [8:0] s);
    if (!ie) return 5'd0;
    return (s[8] | s[3] | s[2] | s[0]) ? 5'd2 : 5'd1;
  endfunction
  function automatic logic [4:0] rxsrc(input logic ie, input logic [8:0] f);
    if (!ie) return 5'd0;
    return (|f[7:0]) ? 5'd8 : 5'd4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic chkr(input string tag, input logic [10:0] a, input logic [31:0] exp);
    host_addr = a; #1;
    chk(tag, host_rdata, exp);
  endtask

  task automatic wait_tx();
    int n = 0;
    while (!tx_req && n < 50) begin @(negedge clk); n++; end
    if (!tx_req) chk("R4 tx_req timeout", 0, 1);
  endtask

  task automatic txdone(input logic [8:0] s);
    @(negedge clk); tx_done = 1; tx_status = s;
    @(negedge clk); tx_done = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rxdone(input logic [15:0] l, input logic [8:0] f);
    @(negedge clk); rx_done = 1; rx_len = l; rx_flags = f;
    @(negedge clk); rx_done = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int e, seed;
    seed = $urandom(17);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 tx_req", tx_req, 0);
    chk("R1 rx_ready", rx_ready, 0);
    chkr("R1 source", 11'h004, 0);
    chkr("R1 mask", 11'h008, 0);
    chkr("R1 split", 11'h020, 64);
    chkr("R1 table", sa(3), 0);
    // R2 table mapping
    hw(aa(10), 32'hDEADBEEF);
    hw(sa(10), 32'h1234_0567);
    chkr("R2 addr word", aa(10), 32'hDEADBEEF);
    chkr("R2 status word", sa(10), 32'h1234_0567);

    hw(11'h020, 4);
    hw(11'h008, 5'h1F);
    // R5 stall on non-ready descriptor
    hw(aa(1), 32'h2000);
    hw(sa(1), 32'h0064_A000);
    repeat (5) @(negedge clk);
    chk("R5 no skip", tx_req, 0);
    // R4 start
    hw(aa(0), 32'h1000);
    hw(sa(0), 32'h003C_D800);
    wait_tx();
    chk("R4 len", tx_len, 60);
    chk("R4 addr", tx_addr, 32'h1000);
    chk("R4 pad", tx_pad, 1);
    chk("R4 crc", tx_crc, 1);
    txdone(9'h000);
    chkr("R6 writeback", sa(0), txwb(16'd60, 4'b1011, 9'h000));
    chkr("R9 tx frame src", 11'h004, 1);
    chk("R11 irq set", irq, 1);
    hw(11'h004, 32'h1F);
    chkr("R11 w1c", 11'h004, 0);
    chk("R11 irq cleared", irq, 0);
    // desc1 next, irq bit clear
    wait_tx();
    chk("R5 next desc len", tx_len, 100);
    chk("R5 next desc addr", tx_addr, 32'h2000);
    txdone(9'h100);
    chkr("R6 writeback status", sa(1), txwb(16'd100, 4'b0100, 9'h100));
    chkr("R9 no irq bit", 11'h004, 0);
    // R8 wrap back to desc0
    hw(sa(0), 32'h0040_C000);
    wait_tx();
    chk("R8 wrap addr", tx_addr, 32'h1000);
    chk("R8 wrap len", tx_len, 64);
    txdone(9'h004);
    chkr("R9 tx error src", 11'h004, 2);
    hw(11'h008, 0);
    chk("R11 masked", irq, 0);
    hw(11'h008, 5'h1F);
    hw(11'h004, 32'h1F);

    // random transmit
    e = 1;
    for (int k = 0; k < 12; k++) begin
      logic [15:0] l; logic [3:0] c; logic [31:0] a; logic [8:0] s;
      l = 16'($urandom_range(1, 1536)); c = 4'($urandom_range(0, 15));
      a = $urandom; s = 9'($urandom_range(0, 511));
      hw(aa(e), a);
      hw(sa(e), {l, 1'b1, c, 11'd0});
      wait_tx();
      chk("R4 rnd len", tx_len, l);
      chk("R4 rnd addr", tx_addr, a);
      chk("R4 rnd pad", tx_pad, c[1]);
      chk("R4 rnd crc", tx_crc, c[0]);
      txdone(s);
      chkr("R6 rnd writeback", sa(e), txwb(l, c, s));
      chkr("R9 rnd src", 11'h004, txsrc(c[3], s));
      hw(11'h004, 32'h1F);
      e = (c[2] || e == 3) ? 0 : e + 1;
    end

    // R10 drop with no empty buffer
    chk("R7 not offered", rx_ready, 0);
    rxdone(16'd80, 9'h0);
    chkr("R10 busy src", 11'h004, 5'h10);
    hw(11'h004, 32'h1F);
    // R11 set wins over clear
    @(negedge clk); host_wr = 1; host_addr = 11'h004; host_wdata = 32'h10; rx_done = 1;
    @(negedge clk); host_wr = 0; rx_done = 0;
    chkr("R11 set beats clear", 11'h004, 5'h10);
    hw(11'h004, 32'h1F);
    // R7 receive
    hw(aa(4), 32'h8000);
    hw(sa(4), 32'h0000_C000);
    chk("R7 ready", rx_ready, 1);
    chk("R7 rx_addr", rx_addr, 32'h8000);
    rxdone(16'd64, 9'h000);
    chkr("R7 writeback", sa(4), rxwb(16'd64, 2'b10, 9'h000));
    chkr("R9 rx frame src", 11'h004, 5'h04);
    hw(11'h004, 32'h1F);
    hw(aa(5), 32'h9000);
    hw(sa(5), 32'h0000_E000);
    chk("R7 next addr", rx_addr, 32'h9000);
    rxdone(16'd1518, 9'h002);
    chkr("R7 writeback err", sa(5), rxwb(16'd1518, 2'b11, 9'h002));
    chkr("R9 rx error src", 11'h004, 5'h08);
    hw(11'h004, 32'h1F);
    hw(sa(4), 32'h0000_C000);
    chk("R8 rx wrap ready", rx_ready, 1);
    chk("R8 rx wrap addr", rx_addr, 32'h8000);
    rxdone(16'd100, 9'h100);
    chkr("R9 control frame not error", 11'h004, 5'h04);
    hw(11'h004, 32'h1F);

    // random receive
    e = 1;
    for (int k = 0; k < 10; k++) begin
      logic [15:0] l; logic [1:0] c; logic [31:0] a; logic [8:0] f;
      l = 16'($urandom_range(64, 1522)); c = 2'($urandom_range(0, 3));
      a = $urandom; f = 9'($urandom_range(0, 511));
      hw(aa(4 + e), a);
      hw(sa(4 + e), {16'd0, 1'b1, c, 13'd0});
      chk("R7 rnd ready", rx_ready, 1);
      chk("R7 rnd addr", rx_addr, a);
      rxdone(l, f);
      chk("R7 rnd withdrawn", rx_ready, 0);
      chkr("R7 rnd writeback", sa(4 + e), rxwb(l, c, f));
      chkr("R9 rnd src", 11'h004, rxsrc(c[1], f));
      hw(11'h004, 32'h1F);
      e = c[0] ? 0 : e + 1;
    end

    // R3 split clamp and receive start
    hw(11'h020, 200);
    chkr("R3 clamp", 11'h020, 128);
    hw(11'h020, 6);
    hw(aa(6), 32'hA000);
    hw(sa(6), 32'h0000_8000);
    chk("R3 rx start ready", rx_ready, 1);
    chk("R3 rx start addr", rx_addr, 32'hA000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule